// File: doc/BRIEF.md
# Serial-Port Pin General-Purpose I/O Controller

This block lets the pins of a buffered serial port serve as general-purpose I/O while the shifting engine behind them is idle. It sits between the serial engine and the pads. It holds one 16-bit configuration register. Depending on two ownership conditions, it drives each pin either from the engine's own signals or from that register. The engine's reset status and a per-direction enable bit decide who owns each pin group. The receive frame-sync and clock pins, and the receive data pin, belong to the receive group. The transmit frame-sync and clock pins, and the transmit data pin, belong to the transmit group. The shared external clock input needs both groups to be owned.

Each frame-sync and clock pin has its own direction bit and its own value bit. As an output, the value bit drives the pad. As an input, the value bit is read-only and reports the pad level after a two-flop synchronizer. The transmit data pin only ever drives. The receive data pin and the external clock pin only ever listen. Pad levels are always passed raw to the engine.

Top module: `sp_pin_gpio`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all direction, enable, value and transmit-data bits read 0, and every pad output and output-enable follows the engine.
- R2: The transmit group (pin indices 1 = transmit clock and 3 = transmit frame-sync, plus the transmit data pin) is GPIO-owned exactly while tx_rst_active is 1 and enable bit 13 is 1.
- R3: The receive group (pin indices 0 = receive clock and 2 = receive frame-sync, plus the receive data pin) is GPIO-owned exactly while rx_rst_active is 1 and enable bit 12 is 1.
- R4: For an owned frame-sync or clock pin i, pad_cf_oe[i] equals direction bit 8+i (1 = output, 0 = input), and pad_cf_o[i] equals value bit i.
- R5: Value bit i reads the stored value when pin i is owned with direction 1. Otherwise it reads the pad level, delayed by two clock edges. Writes to it are then ignored.
- R6: While the transmit group is owned, pad_dx_oe is 1 and pad_dx_o equals bit 5. Bit 5 reads back the stored value.
- R7: Bit 4 reads the synchronized receive-data pad level while the receive group is owned, and 0 otherwise.
- R8: Bit 6 reads the synchronized external clock pad level only while both groups are owned, and 0 otherwise.
- R9: A write updates value bit i only if pin i was owned with direction 1 before that write. It updates bit 5 only if the transmit group was owned before that write. Direction and enable bits are always written.
- R10: Pins that are not owned drive the engine's output and output-enable. eng_cf_i, eng_dr_i and eng_clks_i always equal the raw pads.
- R11: Bits 7, 14 and 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Register read view |
| tx_rst_active | input | 1 | Transmit section of the engine is held in reset |
| rx_rst_active | input | 1 | Receive section of the engine is held in reset |
| eng_cf_o | input | 4 | Engine drive values for receive clock, transmit clock, receive frame-sync, transmit frame-sync |
| eng_cf_oe | input | 4 | Engine output enables for the same pins |
| eng_cf_i | output | 4 | Raw pad levels of the same pins to the engine |
| eng_dx_o | input | 1 | Engine transmit data |
| eng_dx_oe | input | 1 | Engine transmit data enable |
| eng_dr_i | output | 1 | Raw receive data pad to the engine |
| eng_clks_i | output | 1 | Raw external clock pad to the engine |
| pad_cf_i | input | 4 | Pad input levels of the four frame-sync and clock pins |
| pad_cf_o | output | 4 | Pad drive values |
| pad_cf_oe | output | 4 | Pad output enables |
| pad_dx_o | output | 1 | Transmit data pad drive |
| pad_dx_oe | output | 1 | Transmit data pad enable |
| pad_dr_i | input | 1 | Receive data pad level |
| pad_clks_i | input | 1 | External clock pad level |

## Verification
On every cycle, the assertions check four things. Stored value and transmit-data bits never change unless the matching pin is an owned output. Pins that are not owned drive exactly what the engine drives. The receive-data and external-clock status bits stay at zero without the required ownership. The bench covers what spans several operations. This includes the two-edge read latency of pad levels, and that a write made before ownership leaves no trace once ownership begins. It also covers the reset values, and the hand-back of one group to the engine while the other group stays in GPIO mode.

// File: rtl/sp_gpio_pkg.sv
// Package: field positions of the pin-control register shared by the
// register file, the bench-facing top and any neighbour decoding it.
// Assumes a 16-bit register and four bidirectional clock/frame-sync pins.
package sp_gpio_pkg;
    localparam int CFG_W    = 16;
    localparam int NPIN     = 4;   // 0 rx clk, 1 tx clk, 2 rx fsync, 3 tx fsync
    localparam int VAL_LSB  = 0;
    localparam int DR_BIT   = 4;
    localparam int DX_BIT   = 5;
    localparam int CLKS_BIT = 6;
    localparam int DIR_LSB  = 8;
    localparam int RXEN_BIT = 12;
    localparam int TXEN_BIT = 13;
endpackage

// File: rtl/sp_gpio_sync.sv
// Module: multi-bit level synchronizer.
// Each bit passes through STAGES flops; assumes the inputs are
// quasi-static levels, so bits need not stay coherent with each other.
module sp_gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // shift pad levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sp_gpio_regs.sv
// Module: configuration register and ownership decode.
// Holds the direction, enable, value and transmit-data bits. Works out
// which pins the GPIO function owns, and builds the read view. Writes
// to the value bits are gated by the ownership in force before the write.
module sp_gpio_regs
    import sp_gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    input  logic             tx_rst_active,
    input  logic             rx_rst_active,
    input  logic [NPIN-1:0]  sync_cf,
    input  logic             sync_dr,
    input  logic             sync_clks,
    output logic [CFG_W-1:0] rdata,
    output logic [NPIN-1:0]  val,
    output logic [NPIN-1:0]  dir,
    output logic             dx_stat,
    output logic [NPIN-1:0]  pin_own,
    output logic             tx_own,
    output logic             rx_own
);
    logic [NPIN-1:0] val_q, dir_q;
    logic            dx_q, txen_q, rxen_q;
    logic [CFG_W-1:0] unused_wbits;

    assign unused_wbits = wdata;
    assign tx_own = tx_rst_active & txen_q;
    assign rx_own = rx_rst_active & rxen_q;

    // map each pin onto its direction group (odd = transmit)
    for (genvar g = 0; g < NPIN; g++) begin : g_own
        if (g % 2 == 1) begin : g_tx
            assign pin_own[g] = tx_own;
        end else begin : g_rx
            assign pin_own[g] = rx_own;
        end
    end

    // register update; value bits gated by prior ownership and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            dir_q  <= '0;
            dx_q   <= 1'b0;
            txen_q <= 1'b0;
            rxen_q <= 1'b0;
        end else if (wr_en) begin
            dir_q  <= wdata[DIR_LSB +: NPIN];
            txen_q <= wdata[TXEN_BIT];
            rxen_q <= wdata[RXEN_BIT];
            for (int i = 0; i < NPIN; i++) begin
                if (pin_own[i] && dir_q[i]) val_q[i] <= wdata[VAL_LSB + i];
            end
            if (tx_own) dx_q <= wdata[DX_BIT];
        end
    end

    // read view: stored value for owned outputs, sampled level otherwise
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NPIN; i++) begin
            rdata[VAL_LSB + i] = (pin_own[i] && dir_q[i]) ? val_q[i] : sync_cf[i];
        end
        rdata[DR_BIT]   = rx_own & sync_dr;
        rdata[DX_BIT]   = dx_q;
        rdata[CLKS_BIT] = tx_own & rx_own & sync_clks;
        rdata[DIR_LSB +: NPIN] = dir_q;
        rdata[RXEN_BIT] = rxen_q;
        rdata[TXEN_BIT] = txen_q;
    end

    assign val     = val_q;
    assign dir     = dir_q;
    assign dx_stat = dx_q;

    for (genvar g = 0; g < NPIN; g++) begin : g_chk
        // R9
        val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pin_own[g] && dir_q[g]) |=> (val_q[g] == $past(val_q[g])));
    end

    // R6
    dx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_own |=> (dx_q == $past(dx_q)));
endmodule

// File: rtl/sp_gpio_pinmux.sv
// Module: pad drive selection.
// Owned clock/frame-sync pins take their enable from the direction bit and
// their drive from the value bit. The owned transmit data pin always
// drives the stored transmit-data bit. Pins that are not owned pass
// the engine's signals through.
module sp_gpio_pinmux
    import sp_gpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_own,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] val,
    input  logic            tx_own,
    input  logic            dx_stat,
    input  logic [NPIN-1:0] eng_o,
    input  logic [NPIN-1:0] eng_oe,
    input  logic            eng_dx_o,
    input  logic            eng_dx_oe,
    output logic [NPIN-1:0] pad_o,
    output logic [NPIN-1:0] pad_oe,
    output logic            pad_dx_o,
    output logic            pad_dx_oe
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        // choose register or engine as the source of this pin
        always_comb begin
            if (pin_own[g]) begin
                pad_oe[g] = dir[g];
                pad_o[g]  = val[g];
            end else begin
                pad_oe[g] = eng_oe[g];
                pad_o[g]  = eng_o[g];
            end
        end

        // R10
        eng_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_own[g] |-> (pad_o[g] == eng_o[g] && pad_oe[g] == eng_oe[g]));
    end

    // transmit data pin: always an output when owned
    always_comb begin
        if (tx_own) begin
            pad_dx_oe = 1'b1;
            pad_dx_o  = dx_stat;
        end else begin
            pad_dx_oe = eng_dx_oe;
            pad_dx_o  = eng_dx_o;
        end
    end
endmodule

// File: rtl/sp_pin_gpio.sv
// Module: serial-port pin GPIO controller (top).
// Places a two-flop synchronizer on the pad inputs, then the register
// file, then the pad drive mux. It assumes the engine's reset flags are
// synchronous to clk.
module sp_pin_gpio
    import sp_gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata,
    input  logic        tx_rst_active,
    input  logic        rx_rst_active,
    input  logic [3:0]  eng_cf_o,
    input  logic [3:0]  eng_cf_oe,
    output logic [3:0]  eng_cf_i,
    input  logic        eng_dx_o,
    input  logic        eng_dx_oe,
    output logic        eng_dr_i,
    output logic        eng_clks_i,
    input  logic [3:0]  pad_cf_i,
    output logic [3:0]  pad_cf_o,
    output logic [3:0]  pad_cf_oe,
    output logic        pad_dx_o,
    output logic        pad_dx_oe,
    input  logic        pad_dr_i,
    input  logic        pad_clks_i
);
    localparam int SW = NPIN + 2;

    logic [SW-1:0]   sync_out;
    logic [NPIN-1:0] val, dir, pin_own;
    logic            dx_stat, tx_own, rx_own;

    assign eng_cf_i   = pad_cf_i;
    assign eng_dr_i   = pad_dr_i;
    assign eng_clks_i = pad_clks_i;

    sp_gpio_sync #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pad_clks_i, pad_dr_i, pad_cf_i}),
        .dout (sync_out)
    );

    sp_gpio_regs regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_wr),
        .wdata        (cfg_wdata),
        .tx_rst_active(tx_rst_active),
        .rx_rst_active(rx_rst_active),
        .sync_cf      (sync_out[NPIN-1:0]),
        .sync_dr      (sync_out[NPIN]),
        .sync_clks    (sync_out[NPIN+1]),
        .rdata        (cfg_rdata),
        .val          (val),
        .dir          (dir),
        .dx_stat      (dx_stat),
        .pin_own      (pin_own),
        .tx_own       (tx_own),
        .rx_own       (rx_own)
    );

    sp_gpio_pinmux mux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_own  (pin_own),
        .dir      (dir),
        .val      (val),
        .tx_own   (tx_own),
        .dx_stat  (dx_stat),
        .eng_o    (eng_cf_o),
        .eng_oe   (eng_cf_oe),
        .eng_dx_o (eng_dx_o),
        .eng_dx_oe(eng_dx_oe),
        .pad_o    (pad_cf_o),
        .pad_oe   (pad_cf_oe),
        .pad_dx_o (pad_dx_o),
        .pad_dx_oe(pad_dx_oe)
    );

    // R7
    dr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_rst_active && cfg_rdata[RXEN_BIT]) |-> !cfg_rdata[DR_BIT]);

    // R8
    clks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_rst_active && rx_rst_active && cfg_rdata[TXEN_BIT] && cfg_rdata[RXEN_BIT])
        |-> !cfg_rdata[CLKS_BIT]);

    // R11
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] == 1'b0 && cfg_rdata[15:14] == 2'b00);
endmodule

// File: tb/sp_pin_gpio_tb_top.sv
`timescale 1ns/1ps
module sp_pin_gpio_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, cfg_wr, tx_rst_active, rx_rst_active;
    logic [15:0] cfg_wdata, cfg_rdata;
    logic [3:0]  eng_cf_o, eng_cf_oe, eng_cf_i, pad_cf_i, pad_cf_o, pad_cf_oe;
    logic        eng_dx_o, eng_dx_oe, eng_dr_i, eng_clks_i;
    logic        pad_dx_o, pad_dx_oe, pad_dr_i, pad_clks_i;

    sp_pin_gpio dut_i (.*);

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // bench model of the register
    logic [3:0] m_val, m_dir;
    logic       m_dx, m_txen, m_rxen;

    function automatic logic own_tx(); return tx_rst_active & m_txen; endfunction
    function automatic logic own_rx(); return rx_rst_active & m_rxen; endfunction
    function automatic logic own_pin(int i); return (i % 2 == 1) ? own_tx() : own_rx(); endfunction

    function automatic logic [15:0] exp_rdata();
        logic [15:0] r = '0;
        for (int i = 0; i < 4; i++) r[i] = (own_pin(i) && m_dir[i]) ? m_val[i] : pad_cf_i[i];
        r[4] = own_rx() & pad_dr_i;
        r[5] = m_dx;
        r[6] = own_tx() & own_rx() & pad_clks_i;
        r[11:8] = m_dir;
        r[12] = m_rxen;
        r[13] = m_txen;
        return r;
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_val = '0; m_dir = '0; m_dx = 0; m_txen = 0; m_rxen = 0;
    endtask

    // write at the next edge; model uses ownership before the write (R9)
    task automatic do_write(logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_wdata = d;
        for (int i = 0; i < 4; i++) if (own_pin(i) && m_dir[i]) m_val[i] = d[i];
        if (own_tx()) m_dx = d[5];
        m_dir = d[11:8]; m_rxen = d[12]; m_txen = d[13];
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all();
        logic [3:0] eo, eoe;
        for (int i = 0; i < 4; i++) begin
            eo[i]  = own_pin(i) ? m_val[i] : eng_cf_o[i];
            eoe[i] = own_pin(i) ? m_dir[i] : eng_cf_oe[i];
        end
        chk("R4 R10", "pad_cf_o", {12'd0, pad_cf_o}, {12'd0, eo});
        chk("R4 R10", "pad_cf_oe", {12'd0, pad_cf_oe}, {12'd0, eoe});
        chk("R6", "pad_dx", {14'd0, pad_dx_oe, pad_dx_o},
            own_tx() ? {14'd0, 1'b1, m_dx} : {14'd0, eng_dx_oe, eng_dx_o});
        chk("R10", "eng_in", {10'd0, eng_clks_i, eng_dr_i, eng_cf_i},
            {10'd0, pad_clks_i, pad_dr_i, pad_cf_i});
        chk("R5", "rdata value bits", {12'd0, cfg_rdata[3:0]}, {12'd0, exp_rdata() & 16'h000F});
        chk("R7", "rdata dr", {15'd0, cfg_rdata[4]}, {15'd0, exp_rdata()[4]});
        chk("R8", "rdata clks", {15'd0, cfg_rdata[6]}, {15'd0, exp_rdata()[6]});
        chk("R11", "rdata full", cfg_rdata, exp_rdata());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; cfg_wr = 0; cfg_wdata = '0;
        tx_rst_active = 1; rx_rst_active = 1;
        eng_cf_o = 4'b0110; eng_cf_oe = 4'b1010; eng_dx_o = 1; eng_dx_oe = 1;
        pad_cf_i = 4'b0101; pad_dr_i = 1; pad_clks_i = 1;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        settle();
        // R1: reset clears the register; pads follow the engine
        chk("R1", "ctrl after reset", cfg_rdata & 16'hFFF0, 16'h0000);
        chk("R1", "pads after reset", {8'd0, pad_cf_oe, pad_cf_o}, {8'd0, eng_cf_oe, eng_cf_o});
        chk("R1", "dx after reset", {14'd0, pad_dx_oe, pad_dx_o}, {14'd0, eng_dx_oe, eng_dx_o});
        check_all();

        // R9: value and transmit-data writes made before ownership are dropped
        do_write(16'h0F2F);
        do_write(16'h3F2F);
        settle();
        chk("R9", "value ignored before ownership", {12'd0, pad_cf_o}, 16'h0000);
        chk("R9", "dx ignored before ownership", {15'd0, pad_dx_o}, 16'h0000);
        check_all();
        do_write(16'h3F2F);
        settle();
        chk("R4", "owned outputs drive", {8'd0, pad_cf_oe, pad_cf_o}, 16'h00FF);
        chk("R6", "dx owned", {14'd0, pad_dx_oe, pad_dx_o}, 16'h0003);
        check_all();

        // R2: transmit section leaves reset, its pins return to the engine
        eng_cf_o = 4'b0000; eng_cf_oe = 4'b0000; eng_dx_oe = 0; eng_dx_o = 0;
        tx_rst_active = 0;
        @(negedge clk);
        chk("R2", "tx pins to engine", {8'd0, pad_cf_oe, pad_cf_o}, 16'h0055);
        chk("R2", "dx to engine", {14'd0, pad_dx_oe, pad_dx_o}, 16'h0000);
        check_all();
        // R3: receive section leaves reset too
        rx_rst_active = 0;
        @(negedge clk);
        chk("R3", "rx pins to engine", {8'd0, pad_cf_oe, pad_cf_o}, 16'h0000);
        check_all();
        tx_rst_active = 1; rx_rst_active = 1;

        // R5: inputs read the pad after two edges, and writes do not stick
        do_write(16'h3000);
        pad_cf_i = 4'b0000;
        settle();
        @(negedge clk);
        pad_cf_i = 4'b1010;
        @(negedge clk);
        chk("R5", "one edge later still old", {12'd0, cfg_rdata[3:0]}, 16'h0000);
        @(negedge clk);
        chk("R5", "two edges later new", {12'd0, cfg_rdata[3:0]}, 16'h000A);
        do_write(16'h3005);
        settle();
        chk("R5", "input value bits not writable", {12'd0, cfg_rdata[3:0]}, 16'h000A);

        // R8 and R7: external clock needs both groups; receive data needs receive
        pad_clks_i = 1; pad_dr_i = 1;
        settle();
        chk("R8", "clks both owned", {15'd0, cfg_rdata[6]}, 16'h0001);
        chk("R7", "dr owned", {15'd0, cfg_rdata[4]}, 16'h0001);
        tx_rst_active = 0;
        @(negedge clk);
        chk("R8", "clks only rx owned", {15'd0, cfg_rdata[6]}, 16'h0000);
        chk("R7", "dr still owned", {15'd0, cfg_rdata[4]}, 16'h0001);
        rx_rst_active = 0; tx_rst_active = 1;
        @(negedge clk);
        chk("R7", "dr not owned", {15'd0, cfg_rdata[4]}, 16'h0000);
        chk("R8", "clks only tx owned", {15'd0, cfg_rdata[6]}, 16'h0000);

        // random mix
        for (int it = 0; it < 400; it++) begin
            @(negedge clk);
            tx_rst_active = ($urandom % 4) != 0;
            rx_rst_active = ($urandom % 4) != 0;
            eng_cf_o = 4'($urandom); eng_cf_oe = 4'($urandom);
            eng_dx_o = 1'($urandom); eng_dx_oe = 1'($urandom);
            pad_cf_i = 4'($urandom); pad_dr_i = 1'($urandom); pad_clks_i = 1'($urandom);
            if ($urandom % 3 != 0) begin
                logic [15:0] d = 16'($urandom);
                if ($urandom % 4 != 0) d[13:12] = 2'b11;
                do_write(d);
            end
            settle();
            check_all();
        end

        // R1: reset in the middle of use
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        settle();
        chk("R1", "ctrl after second reset", cfg_rdata & 16'hFFF0, 16'h0000);
        check_all();

        finish_run();
    end
endmodule